// File: doc/BRIEF.md
# BCD Alarm Compare Unit

This block watches a running calendar clock, presented as six BCD bytes (hundredths, seconds, minutes, hours, day, month), and compares it against six programmable alarm bytes. Each alarm byte has its own compare enable. A disabled byte counts as a match and never holds the alarm back. When every enabled byte agrees with the clock, a sticky alarm status bit is set. A separate interrupt request follows that bit only while the alarm interrupt enable is on.

Software loads the alarm bytes through a small write and read port. It chooses which bytes take part through the enable mask. It clears the status bit by writing a one into status bit 3, which reaches the block as a single strobe. A byte whose comparison is off keeps its storage, so it can serve as general-purpose RAM.

Detection runs as a two-state machine. `ST_WAIT` means the combined equality is low. `ST_HOLD` means a match has been seen and is still present. The transition `WAIT->HOLD` happens when the combined equality goes high, and it issues one set event for the status bit. The transition `HOLD->WAIT` happens when the equality drops. Both states otherwise remain where they are.

Top module: `bcd_alarm_unit`

## Requirements
- R1: Alarm byte i is compared with clock byte i, where `time_i[8*i+7:8*i]` is byte i. Byte 0 is hundredths, byte 1 seconds, byte 2 minutes, byte 3 hours, byte 4 day and byte 5 month. An enabled byte that differs blocks the alarm.
- R2: A byte whose bit in `cmp_en` is 0 is treated as always equal.
- R3: When all enabled bytes equal the clock in the same cycle, `alarm_flag` reads 1 from the cycle after that clock edge.
- R4: `alarm_flag` is set on a match even while `irq_en` is 0.
- R5: `alarm_irq` is 1 only when both `alarm_flag` and `irq_en` are 1.
- R6: `alarm_flag` stays set until a cycle with `clr_wr` high, which stands for writing a one into status bit 3. Status writes that do not carry that one leave the flag unchanged.
- R7: A write with `wr_en` high stores `wr_data` at `wr_addr` (0 to 5), whether or not that byte's comparison is enabled. `rd_data` returns the byte at `rd_addr` in the same cycle. Addresses 6 and 7 read as 0x00 and ignore writes.
- R8: Only a rising edge of the combined equality sets the flag. If the match is held and the flag is cleared, the flag is not set again until the equality drops and returns.
- R9: With `cmp_en` all zero, no alarm is ever raised.
- R10: If a clear and a new match fall in the same cycle, the flag ends set.
- R11: With hours = 0x03, minutes = 0x15, seconds = hundredths = 0x00 and day and month disabled, the alarm fires at 03:15:00.00 but not at 03:14:59.99.
- R12: After reset all alarm bytes read 0x00 and `alarm_flag` and `alarm_irq` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| time_i | input | 48 | Current BCD time, byte 0 hundredths up to byte 5 month |
| wr_en | input | 1 | Alarm byte write strobe |
| wr_addr | input | 3 | Alarm byte write address |
| wr_data | input | 8 | Alarm byte write data |
| rd_addr | input | 3 | Alarm byte read address |
| rd_data | output | 8 | Alarm byte read data (combinational) |
| cmp_en | input | 6 | Per-byte compare enable |
| irq_en | input | 1 | Alarm interrupt enable |
| clr_wr | input | 1 | Status write carrying a one in bit 3 (clear) |
| alarm_flag | output | 1 | Sticky alarm status |
| alarm_irq | output | 1 | Gated alarm interrupt request |

## Verification
The assertions check the following on every cycle:
- The interrupt is gated by its enable and by the flag.
- Each set event reaches the flag.
- The flag holds without a clear and drops after a clear that is not racing a set event.
- Set events never occur back to back.
- An all-zero enable mask never yields a combined match.

Several behaviours depend on particular values and sequences, so only the bench scenarios can show them:
- The byte ordering of the clock word.
- The daily BCD example.
- Per-byte blocking by an enabled month byte.
- Reuse of disabled bytes as storage.
- The absence of a re-set while a match is held after a clear.

// File: rtl/bcd_alarm_pkg.sv
package bcd_alarm_pkg;
    localparam int unsigned ALM_BYTES  = 6;
    localparam int unsigned ALM_BYTE_W = 8;

    typedef enum logic [0:0] {
        ST_WAIT = 1'b0,
        ST_HOLD = 1'b1
    } alarm_state_e;
endpackage

// File: rtl/bcd_alarm_regs.sv
module bcd_alarm_regs #(
    parameter int unsigned NB = 6,
    parameter int unsigned BW = 8,
    parameter int unsigned AW = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            we,
    input  logic [AW-1:0]   waddr,
    input  logic [BW-1:0]   wdata,
    input  logic [AW-1:0]   raddr,
    output logic [BW-1:0]   rdata,
    output logic [NB*BW-1:0] bytes_o
);
    // one storage byte per alarm field; unmapped addresses hit nothing
    for (genvar g = 0; g < NB; g++) begin : g_byte
        logic [BW-1:0] q;
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                q <= '0;
            end else if (we && (waddr == AW'(g))) begin
                q <= wdata;
            end
        end
        assign bytes_o[g*BW +: BW] = q;
    end

    always_comb begin
        rdata = '0;
        for (int i = 0; i < NB; i++) begin
            if (raddr == AW'(i)) begin
                rdata = bytes_o[i*BW +: BW];
            end
        end
    end
endmodule

// File: rtl/bcd_alarm_match.sv
module bcd_alarm_match #(
    parameter int unsigned NB = 6,
    parameter int unsigned BW = 8
) (
    input  logic [NB*BW-1:0] time_i,
    input  logic [NB*BW-1:0] ref_i,
    input  logic [NB-1:0]    en_i,
    output logic             match_all
);
    logic [NB-1:0] hit;

    // a byte left out of the comparison is forced to agree
    for (genvar g = 0; g < NB; g++) begin : g_cmp
        assign hit[g] = ~en_i[g] | (time_i[g*BW +: BW] == ref_i[g*BW +: BW]);
    end

    // an empty mask must not count as a permanent match
    assign match_all = (&hit) & (|en_i);
endmodule

// File: rtl/bcd_alarm_ctrl.sv
module bcd_alarm_ctrl
    import bcd_alarm_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic match_all,
    input  logic clr_i,
    output logic fire_o,
    output logic flag_o
);
    alarm_state_e state_q, state_d;
    logic         flag_q;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_WAIT;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions and the one-cycle set event
    always_comb begin
        state_d = state_q;
        fire_o  = 1'b0;
        unique case (state_q)
            ST_WAIT: begin
                if (match_all) begin
                    state_d = ST_HOLD;
                    fire_o  = 1'b1;
                end
            end
            ST_HOLD: begin
                if (!match_all) begin
                    state_d = ST_WAIT;
                end
            end
        endcase
    end

    // sticky status: a set event outranks a clear in the same cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
        end else if (fire_o) begin
            flag_q <= 1'b1;
        end else if (clr_i) begin
            flag_q <= 1'b0;
        end
    end

    assign flag_o = flag_q;
endmodule

// File: rtl/bcd_alarm_unit.sv
module bcd_alarm_unit
    import bcd_alarm_pkg::*;
#(
    parameter int unsigned NB = ALM_BYTES,
    parameter int unsigned BW = ALM_BYTE_W,
    localparam int unsigned AW = (NB > 1) ? $clog2(NB + 1) : 1,
    localparam int unsigned TW = NB * BW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [TW-1:0] time_i,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [BW-1:0] wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [BW-1:0] rd_data,
    input  logic [NB-1:0] cmp_en,
    input  logic          irq_en,
    input  logic          clr_wr,
    output logic          alarm_flag,
    output logic          alarm_irq
);
    logic [TW-1:0] ref_bytes;
    logic          match_all;
    logic          fire;

    bcd_alarm_regs #(.NB(NB), .BW(BW), .AW(AW)) regs_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (wr_en),
        .waddr   (wr_addr),
        .wdata   (wr_data),
        .raddr   (rd_addr),
        .rdata   (rd_data),
        .bytes_o (ref_bytes)
    );

    bcd_alarm_match #(.NB(NB), .BW(BW)) match_i (
        .time_i    (time_i),
        .ref_i     (ref_bytes),
        .en_i      (cmp_en),
        .match_all (match_all)
    );

    bcd_alarm_ctrl ctrl_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .match_all (match_all),
        .clr_i     (clr_wr),
        .fire_o    (fire),
        .flag_o    (alarm_flag)
    );

    assign alarm_irq = alarm_flag & irq_en;
endmodule

// File: rtl/bcd_alarm_chk.sv
module bcd_alarm_chk #(
    parameter int unsigned NB = 6
) (
    input logic          clk,
    input logic          rst_n,
    input logic          irq_en,
    input logic          clr_wr,
    input logic [NB-1:0] cmp_en,
    input logic          match_all,
    input logic          fire,
    input logic          alarm_flag,
    input logic          alarm_irq
);
    p_irq_gated_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_en |-> !alarm_irq);

    p_irq_needs_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
        alarm_irq |-> alarm_flag);

    p_set_on_match_r3: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> alarm_flag);

    p_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (alarm_flag && !clr_wr) |=> alarm_flag);

    p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_wr && !fire) |=> !alarm_flag);

    p_single_event_r8: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> !fire);

    p_empty_mask_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_en == '0) |-> !match_all);

    p_match_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && clr_wr) |=> alarm_flag);
endmodule

bind bcd_alarm_unit bcd_alarm_chk #(.NB(NB)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .irq_en     (irq_en),
    .clr_wr     (clr_wr),
    .cmp_en     (cmp_en),
    .match_all  (match_all),
    .fire       (fire),
    .alarm_flag (alarm_flag),
    .alarm_irq  (alarm_irq)
);

// File: tb/bcd_alarm_unit_tb_top.sv
`timescale 1ns/1ps
module bcd_alarm_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [47:0] time_i = '0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic [2:0]  rd_addr = '0;
    logic [7:0]  rd_data;
    logic [5:0]  cmp_en = '0;
    logic        irq_en = 1'b0;
    logic        clr_wr = 1'b0;
    logic        alarm_flag;
    logic        alarm_irq;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    typedef struct {
        string      tag;
        logic       flag;
        logic       irq;
        logic [7:0] rd;
    } exp_t;

    exp_t sb_q[$];
    exp_t cur;

    always #5 clk = ~clk;

    bcd_alarm_unit dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .time_i     (time_i),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .rd_addr    (rd_addr),
        .rd_data    (rd_data),
        .cmp_en     (cmp_en),
        .irq_en     (irq_en),
        .clr_wr     (clr_wr),
        .alarm_flag (alarm_flag),
        .alarm_irq  (alarm_irq)
    );

    // monitor: compares outputs against the queued expectation mid-cycle
    always @(negedge clk) begin
        if (sb_q.size() != 0) begin
            cur = sb_q.pop_front();
            n_checks++;
            if (alarm_flag !== cur.flag || alarm_irq !== cur.irq || rd_data !== cur.rd) begin
                n_errors++;
                $display("FAIL %s: actual flag=%b irq=%b rd=%h expected flag=%b irq=%b rd=%h",
                         cur.tag, alarm_flag, alarm_irq, rd_data, cur.flag, cur.irq, cur.rd);
            end
        end
    end

    function automatic logic [47:0] mk_t(input logic [7:0] mo, input logic [7:0] dy,
                                         input logic [7:0] hr, input logic [7:0] mi,
                                         input logic [7:0] se, input logic [7:0] hu);
        return {mo, dy, hr, mi, se, hu};
    endfunction

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic expect_out(input string tag, input logic f, input logic i, input logic [7:0] rd);
        sb_q.push_back('{tag, f, i, rd});
        @(negedge clk);
        #1;
    endtask

    task automatic wr_byte(input logic [2:0] a, input logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        tick();
        wr_en = 1'b0;
    endtask

    task automatic do_clear();
        clr_wr = 1'b1;
        tick();
        clr_wr = 1'b0;
    endtask

    task automatic summary();
        $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_errors++;
            $display("FAIL watchdog: actual hung expected finish");
            summary();
            $finish;
        end
    end

    initial begin
        tick(); tick();
        expect_out("R12 reset state", 1'b0, 1'b0, 8'h00);
        rst_n = 1'b1;
        tick();

        // R7: storage with all compares off, read back each address
        for (int i = 0; i < 6; i++) wr_byte(3'(i), 8'(i * 8'h11));
        for (int i = 0; i < 6; i++) begin
            rd_addr = 3'(i);
            #1;
            expect_out("R7 readback", 1'b0, 1'b0, 8'(i * 8'h11));
        end
        wr_byte(3'd6, 8'hAB);
        rd_addr = 3'd6;
        #1;
        expect_out("R7 unmapped address", 1'b0, 1'b0, 8'h00);
        rd_addr = 3'd0;

        // R11 setup: 03:15:00.00, day and month disabled
        wr_byte(3'd0, 8'h00);
        wr_byte(3'd1, 8'h00);
        wr_byte(3'd2, 8'h15);
        wr_byte(3'd3, 8'h03);
        cmp_en = 6'b001111;
        irq_en = 1'b1;
        time_i = mk_t(8'h07, 8'h12, 8'h03, 8'h14, 8'h59, 8'h99);
        tick();
        expect_out("R11 one tick before", 1'b0, 1'b0, 8'h00);
        time_i = mk_t(8'h07, 8'h12, 8'h03, 8'h15, 8'h00, 8'h00);
        tick();
        expect_out("R11 R3 R2 alarm at 03:15", 1'b1, 1'b1, 8'h00);

        // R8: held match, clear, no re-set
        tick(); tick();
        do_clear();
        expect_out("R8 clear while held", 1'b0, 1'b0, 8'h00);
        tick(); tick();
        expect_out("R8 no re-set while held", 1'b0, 1'b0, 8'h00);

        // R8 new rising edge, then R6 status write without bit 3
        time_i = mk_t(8'h07, 8'h12, 8'h03, 8'h15, 8'h00, 8'h01);
        tick();
        time_i = mk_t(8'h07, 8'h12, 8'h03, 8'h15, 8'h00, 8'h00);
        tick();
        expect_out("R8 re-set on new edge", 1'b1, 1'b1, 8'h00);
        tick(); tick();
        expect_out("R6 sticky without clear", 1'b1, 1'b1, 8'h00);
        irq_en = 1'b0;
        #1;
        expect_out("R5 irq masked", 1'b1, 1'b0, 8'h00);

        // R4: flag set while interrupt disabled
        time_i = mk_t(8'h07, 8'h12, 8'h03, 8'h16, 8'h00, 8'h00);
        do_clear();
        expect_out("R6 clear", 1'b0, 1'b0, 8'h00);
        time_i = mk_t(8'h07, 8'h12, 8'h03, 8'h15, 8'h00, 8'h00);
        tick();
        expect_out("R4 flag without irq_en", 1'b1, 1'b0, 8'h00);

        // R10: clear and new match in the same cycle
        time_i = mk_t(8'h07, 8'h12, 8'h04, 8'h15, 8'h00, 8'h00);
        tick();
        time_i = mk_t(8'h07, 8'h12, 8'h03, 8'h15, 8'h00, 8'h00);
        do_clear();
        expect_out("R10 match beats clear", 1'b1, 1'b0, 8'h00);

        // R1: enabled month byte blocks, then matches
        wr_byte(3'd5, 8'h08);
        cmp_en = 6'b101111;
        irq_en = 1'b1;
        do_clear();
        expect_out("R1 month mismatch blocks", 1'b0, 1'b0, 8'h00);
        tick();
        expect_out("R1 month mismatch still blocked", 1'b0, 1'b0, 8'h00);
        time_i = mk_t(8'h08, 8'h12, 8'h03, 8'h15, 8'h00, 8'h00);
        tick();
        expect_out("R1 month match fires", 1'b1, 1'b1, 8'h00);

        // R9: empty mask never fires
        cmp_en = 6'b000000;
        do_clear();
        time_i = mk_t(8'h07, 8'h12, 8'h03, 8'h15, 8'h00, 8'h00);
        tick();
        time_i = mk_t(8'h08, 8'h12, 8'h03, 8'h15, 8'h00, 8'h00);
        tick();
        expect_out("R9 empty mask", 1'b0, 1'b0, 8'h00);

        // R7: disabled byte as general storage
        wr_byte(3'd5, 8'h42);
        rd_addr = 3'd5;
        #1;
        expect_out("R7 disabled byte storage", 1'b0, 1'b0, 8'h42);

        done = 1'b1;
        summary();
        $finish;
    end
endmodule